// File: doc/BRIEF.md
# Ingress Record Merger with Header-Strip Descriptor Update

This block merges three streams of packet records into the one stream that feeds classification. The three streams come from the receive path, the control processor and the plugins. Each stream offers one record at a time through a valid/ready handshake. A round-robin arbiter picks which waiting source to serve, and serves one record per grant. The winning record is rebuilt into a common three-word format and held in an output register, which waits for the downstream ready.

Receive records carry only a buffer handle, a frame length and an input port. The block turns each one into a full record that is marked for classification, and its L3 length is the frame length less the 14-byte Ethernet header. For every receive record it also issues one write on a descriptor memory port. That write moves the buffer's start to the IP header at byte 0x18E. It sets both size fields to the stripped length, the free list to 0 and the reference count to 1.

Records from the control processor and from the plugins are already complete. They pass through with two changes. Their source field is stamped, and their input port is forced to the code that marks where they came from. They cause no descriptor write.

Top module: `pkt_ingress_merge`

## Requirements
- R1: After reset, out_valid and dsc_we are 0, and no ready is raised while no source is valid.
- R2: At most one source ready is high in any cycle. While all three sources stay valid and the output drains every cycle, grants rotate receive, control, plugin, receive and so on, and the first grant after reset goes to receive.
- R3: A receive record produces out_rec as follows. Bits [95:92] and [91:88] (output port) are 0. Bits [87:64] hold handle[23:0] and bits [63:48] hold the L3 length. The QID in [47:32], the plugin tag in [31:27] and the stats index in [15:0] are all 0. Bits [26:24] hold rx_port[2:0], and the flags byte in [23:16] is 0x00 (source 00, classify). rx_port[3] is always 0.
- R4: In the cycle that a receive record appears at the output, dsc_we is 1 for that one cycle. dsc_addr carries the full 32-bit handle, both size outputs carry the L3 length, the offset is 0x18E, the free list is 0 and the reference count is 1.
- R5: A control record leaves unchanged except for two fields. Bits [26:24] become 111 and flags bits [2:1] (out_rec[18:17]) become 01. Flags bit 0 (pass-through) and flags bits [7:3] are kept.
- R6: A plugin record leaves unchanged except for two fields. Bits [26:24] become 110 and flags bits [2:1] become 10.
- R7: dsc_we stays 0 for every cycle that follows an accept of a control or plugin record, and for every cycle with no accept.
- R8: While out_valid is 1 and out_ready is 0, out_rec and out_valid hold and no source is given ready. No record is lost across the stall.
- R9: With out_ready held high, one source can deliver a record on every cycle. Each record appears at the output one cycle after its accept.
- R10: The L3 length is frame length minus 14, and it saturates to 0 for frames shorter than 14 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive record offered |
| rx_ready | output | 1 | Receive record taken this cycle |
| rx_handle | input | 32 | Receive buffer handle |
| rx_frame_len | input | 16 | Ethernet frame length in bytes |
| rx_port | input | 4 | Receive input port |
| cp_valid | input | 1 | Control processor record offered |
| cp_ready | output | 1 | Control processor record taken |
| cp_rec | input | 96 | Control processor three-word record |
| pl_valid | input | 1 | Plugin record offered |
| pl_ready | output | 1 | Plugin record taken |
| pl_rec | input | 96 | Plugin three-word record |
| out_valid | output | 1 | Merged record present |
| out_ready | input | 1 | Downstream takes the merged record |
| out_rec | output | 96 | Merged three-word record |
| dsc_we | output | 1 | Descriptor write strobe |
| dsc_addr | output | 32 | Descriptor handle being rewritten |
| dsc_buf_size | output | 16 | New buffer size |
| dsc_pkt_size | output | 16 | New packet size |
| dsc_offset | output | 16 | New byte offset of packet start |
| dsc_free_list | output | 4 | Free list identifier |
| dsc_ref_cnt | output | 8 | Reference count |

## Verification
Suppose the arbiter pointer goes wrong. The next cycle in which all three sources are valid shows it at the source readies, as a repeated or skipped source field in the output. Suppose the output register goes wrong. That shows within one cycle of a stall as a changed or lost record. A wrong stripped length or a wrong descriptor strobe appears one cycle after the receive accept, both in out_rec and on the descriptor port. The bench therefore compares every output cycle of back-to-back sweeps against expected values built arithmetically in the bench.

// File: rtl/imb_pkg.sv
package imb_pkg;
  typedef logic [95:0] rec_t;

  typedef enum logic [1:0] {
    SRC_RX = 2'b00,
    SRC_CP = 2'b01,
    SRC_PL = 2'b10
  } src_e;

  localparam logic [2:0] CP_PORT_CODE = 3'b111;
  localparam logic [2:0] PL_PORT_CODE = 3'b110;

  // field positions inside the merged record
  localparam int LEN_LSB   = 48;
  localparam int PORT_LSB  = 24;
  localparam int FLAGS_LSB = 16;

  function automatic logic [15:0] strip_len(input logic [15:0] frame,
                                            input logic [15:0] hdr);
    return (frame >= hdr) ? (frame - hdr) : 16'd0;
  endfunction

  function automatic rec_t pack_rx(input logic [31:0] handle,
                                   input logic [15:0] l3len,
                                   input logic [2:0]  port);
    rec_t r;
    r = '0;
    r[87:64] = handle[23:0];
    r[LEN_LSB +: 16] = l3len;
    r[PORT_LSB +: 3] = port;
    r[FLAGS_LSB +: 8] = {5'b0, SRC_RX, 1'b0};
    return r;
  endfunction

  function automatic rec_t retag(input rec_t in_rec, input src_e src,
                                 input logic [2:0] port);
    rec_t r;
    r = in_rec;
    r[PORT_LSB +: 3] = port;
    r[FLAGS_LSB+1 +: 2] = src;
    return r;
  endfunction
endpackage

// File: rtl/imb_rr_arb.sv
module imb_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win;
  logic          hit;

  always_comb begin
    gnt = '0;
    win = last_q;
    hit = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = int'(last_q) + off;
      if (cand >= N) cand = cand - N;
      if (!hit && en && req[cand]) begin
        hit       = 1'b1;
        gnt[cand] = 1'b1;
        win       = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (hit) last_q <= win;
  end

  generate
    if (N > 1) begin : g_fair
      p_rr_no_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (&req)) ##1 (en && (&req)) |-> (gnt != $past(gnt)));
    end
  endgenerate
endmodule

// File: rtl/imb_norm.sv
module imb_norm
  import imb_pkg::*;
#(
  parameter logic [15:0] HDR_BYTES = 16'd14
) (
  input  logic [2:0]  sel,
  input  logic [31:0] rx_handle,
  input  logic [15:0] rx_frame_len,
  input  logic [2:0]  rx_port,
  input  rec_t        cp_rec,
  input  rec_t        pl_rec,
  output rec_t        rec,
  output logic [15:0] l3_len
);
  assign l3_len = strip_len(rx_frame_len, HDR_BYTES);

  always_comb begin
    if (sel[0])      rec = pack_rx(rx_handle, l3_len, rx_port);
    else if (sel[1]) rec = retag(cp_rec, SRC_CP, CP_PORT_CODE);
    else if (sel[2]) rec = retag(pl_rec, SRC_PL, PL_PORT_CODE);
    else             rec = '0;
  end
endmodule

// File: rtl/pkt_ingress_merge.sv
module pkt_ingress_merge
  import imb_pkg::*;
#(
  parameter logic [15:0] HDR_BYTES = 16'd14,
  parameter logic [15:0] IP_OFS    = 16'h018E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_handle,
  input  logic [15:0] rx_frame_len,
  input  logic [3:0]  rx_port,
  input  logic        cp_valid,
  output logic        cp_ready,
  input  logic [95:0] cp_rec,
  input  logic        pl_valid,
  output logic        pl_ready,
  input  logic [95:0] pl_rec,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [95:0] out_rec,
  output logic        dsc_we,
  output logic [31:0] dsc_addr,
  output logic [15:0] dsc_buf_size,
  output logic [15:0] dsc_pkt_size,
  output logic [15:0] dsc_offset,
  output logic [3:0]  dsc_free_list,
  output logic [7:0]  dsc_ref_cnt
);
  localparam int NSRC = 3;

  logic            slot_free;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] gnt;
  logic            accept;
  logic            rx_accept;
  rec_t            norm_rec;
  logic [15:0]     l3_len;
  logic [15:0]     dsc_len_q;

  assign slot_free = !out_valid || out_ready;
  assign req       = {pl_valid, cp_valid, rx_valid};
  assign {pl_ready, cp_ready, rx_ready} = gnt;
  assign accept    = |gnt;
  assign rx_accept = gnt[0];

  imb_rr_arb #(.N(NSRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .en    (slot_free),
    .gnt   (gnt)
  );

  imb_norm #(.HDR_BYTES(HDR_BYTES)) u_norm (
    .sel          (gnt),
    .rx_handle    (rx_handle),
    .rx_frame_len (rx_frame_len),
    .rx_port      (rx_port[2:0]),
    .cp_rec       (cp_rec),
    .pl_rec       (pl_rec),
    .rec          (norm_rec),
    .l3_len       (l3_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
      dsc_we    <= 1'b0;
      dsc_addr  <= '0;
      dsc_len_q <= '0;
    end else begin
      dsc_we <= rx_accept;
      if (accept) begin
        out_valid <= 1'b1;
        out_rec   <= norm_rec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (rx_accept) begin
        dsc_addr  <= rx_handle;
        dsc_len_q <= l3_len;
      end
    end
  end

  assign dsc_buf_size  = dsc_len_q;
  assign dsc_pkt_size  = dsc_len_q;
  assign dsc_offset    = IP_OFS;
  assign dsc_free_list = 4'd0;
  assign dsc_ref_cnt   = 8'd1;

  p_one_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pl_ready, cp_ready, rx_ready}));

  p_rx_port_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_port[3]);

  p_rx_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> dsc_we);

  p_only_rx_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ready) |=> !dsc_we);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !(rx_ready || cp_ready || pl_ready));

  p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_valid && rx_ready) || (cp_valid && cp_ready) || (pl_valid && pl_ready))
      |=> out_valid);

  p_write_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=>
      ((17'(dsc_pkt_size) + 17'(HDR_BYTES) == 17'($past(rx_frame_len))) ||
       (dsc_pkt_size == 16'd0 && $past(rx_frame_len) < HDR_BYTES)));
endmodule

// File: tb/sim_pkt_ingress_merge.sv
`timescale 1ns/1ps
module sim_pkt_ingress_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_handle = '0;
  logic [15:0] rx_frame_len = '0;
  logic [3:0]  rx_port = '0;
  logic        cp_valid = 1'b0;
  logic        cp_ready;
  logic [95:0] cp_rec = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [95:0] pl_rec = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [95:0] out_rec;
  logic        dsc_we;
  logic [31:0] dsc_addr;
  logic [15:0] dsc_buf_size, dsc_pkt_size, dsc_offset;
  logic [3:0]  dsc_free_list;
  logic [7:0]  dsc_ref_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_ingress_merge u0 (.*);

  task automatic chk(input bit ok, input string tag,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_pass(input logic [95:0] r,
                                           input logic [2:0] port,
                                           input logic [1:0] src);
    return {r[95:27], port, r[23:19], src, r[16], r[15:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [95:0] exp_rec;
    logic [15:0] exp_len;
    logic [31:0] exp_h;
    logic [95:0] rec_a, rec_b, exp_a, exp_b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0 && dsc_we == 1'b0, "R1", {94'b0, out_valid, dsc_we}, 96'b0);
    chk({rx_ready, cp_ready, pl_ready} == 3'b000, "R1",
        {93'b0, rx_ready, cp_ready, pl_ready}, 96'b0);

    // R2: rotation with all three sources valid
    out_ready = 1'b1;
    rx_valid = 1'b1; rx_handle = 32'h1234_5678; rx_frame_len = 16'd100; rx_port = 4'd2;
    cp_valid = 1'b1; cp_rec = {32'h0AAA_AAAA, 32'h0040_0100, 32'h2800_0001};
    pl_valid = 1'b1; pl_rec = {32'h0BBB_BBBB, 32'h0050_0200, 32'h1000_0002};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R2", {95'b0, out_valid}, 96'd1);
      chk(out_rec[18:17] == 2'(k % 3), "R2", {94'b0, out_rec[18:17]}, 96'(k % 3));
      chk($countones({rx_ready, cp_ready, pl_ready}) <= 1, "R2",
          {93'b0, rx_ready, cp_ready, pl_ready}, 96'b0);
    end
    rx_valid = 1'b0; cp_valid = 1'b0; pl_valid = 1'b0;
    @(negedge clk);

    // R3 R4 R9 R10: back-to-back receive sweep
    exp_rec = '0; exp_len = '0; exp_h = '0;
    for (int i = 0; i <= 56; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid == 1'b1, "R9", {95'b0, out_valid}, 96'd1);
        chk(out_rec == exp_rec, "R3", out_rec, exp_rec);
        chk(out_rec[63:48] == exp_len, "R10", {80'b0, out_rec[63:48]}, {80'b0, exp_len});
        chk(dsc_we && dsc_addr == exp_h && dsc_buf_size == exp_len &&
            dsc_pkt_size == exp_len && dsc_offset == 16'h018E &&
            dsc_free_list == 4'd0 && dsc_ref_cnt == 8'd1, "R4",
            {3'b0, dsc_we, dsc_addr, dsc_buf_size, dsc_pkt_size, dsc_offset, dsc_free_list, dsc_ref_cnt},
            {3'b0, 1'b1, exp_h, exp_len, exp_len, 16'h018E, 4'd0, 8'd1});
      end
      if (i < 56) begin
        logic [15:0] len;
        logic [2:0]  p;
        len = (i == 55) ? 16'hFFFF : (i < 48) ? 16'(i) : 16'(1400 + i * 3);
        p = 3'(i);
        exp_h = 32'hC000_0000 + 32'(i) * 32'h0001_0203;
        rx_valid = 1'b1; rx_handle = exp_h; rx_frame_len = len; rx_port = {1'b0, p};
        exp_len = (len >= 16'd14) ? len - 16'd14 : 16'd0;
        exp_rec = {8'h00, exp_h[23:0], exp_len, 16'h0000, 5'h00, p, 8'h00, 16'h0000};
      end else begin
        rx_valid = 1'b0;
      end
    end

    // R5 R7: control processor sweep
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid && out_rec == exp_rec, "R5", out_rec, exp_rec);
        chk(dsc_we == 1'b0, "R7", {95'b0, dsc_we}, 96'b0);
      end
      if (i < 32) begin
        logic [95:0] r;
        r = {32'hA500_0000 ^ (32'(i) * 32'h0101_0101), 32'(i) * 32'h0037_0049,
             32'(i) * 32'h09F3_1D2B};
        cp_valid = 1'b1; cp_rec = r;
        exp_rec = exp_pass(r, 3'b111, 2'b01);
      end else cp_valid = 1'b0;
    end

    // R6 R7: plugin sweep
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid && out_rec == exp_rec, "R6", out_rec, exp_rec);
        chk(dsc_we == 1'b0, "R7", {95'b0, dsc_we}, 96'b0);
      end
      if (i < 32) begin
        logic [95:0] r;
        r = {32'h5A00_0000 ^ (32'(i) * 32'h0202_0303), 32'(i) * 32'h0011_0CC5,
             ~(32'(i) * 32'h0135_79BD)};
        pl_valid = 1'b1; pl_rec = r;
        exp_rec = exp_pass(r, 3'b110, 2'b10);
      end else pl_valid = 1'b0;
    end

    // R8: stall holds the record and blocks the sources
    @(negedge clk);
    out_ready = 1'b0;
    rec_a = {32'h0F0F_0F0F, 32'h1111_2222, 32'hFFFF_FF01};
    rec_b = {32'h7777_8888, 32'h3333_4444, 32'h0000_0000};
    exp_a = exp_pass(rec_a, 3'b111, 2'b01);
    exp_b = exp_pass(rec_b, 3'b110, 2'b10);
    cp_valid = 1'b1; cp_rec = rec_a;
    @(negedge clk);
    cp_valid = 1'b0;
    chk(out_valid && out_rec == exp_a, "R5", out_rec, exp_a);
    pl_valid = 1'b1; pl_rec = rec_b;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_rec == exp_a, "R8", out_rec, exp_a);
      chk(pl_ready == 1'b0, "R8", {95'b0, pl_ready}, 96'b0);
      chk(dsc_we == 1'b0, "R7", {95'b0, dsc_we}, 96'b0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    pl_valid = 1'b0;
    chk(out_valid && out_rec == exp_b, "R8", out_rec, exp_b);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", {95'b0, out_valid}, 96'b0);
    chk(dsc_we == 1'b0, "R7", {95'b0, dsc_we}, 96'b0);

    finish_run();
  end
endmodule